// File: doc/BRIEF.md
# Oscillator Alarm Supervisor

This block watches a bank of free-running entropy oscillators (up to 32 by default). Each oscillator delivers a one-cycle alarm pulse whenever it misbehaves. The supervisor keeps one alarm counter per oscillator and compares it against a shared, programmable threshold. When an oscillator goes past the threshold, the supervisor switches it off, records it in a sticky stopped-oscillator vector and clears its counter.

A shutdown that happens while an earlier shutdown is still on record raises a sticky overflow flag. Two shutdowns in the same cycle also raise it. Software uses this flag to tell a single recoverable fault from a repeated one. The recovery sequence is to clear the stop record, which also clears the flag, and then rewrite the enable vector.

Software programs five registers through a single-cycle write port: the enable vector, a detune value passed straight to the oscillators, a per-oscillator alarm mask, the stop record and the threshold. In this block the analog oscillators are modelled only by their alarm inputs.

Top module: `osc_alarm_sup`

## Requirements
- R1: After reset, `oscEnable`, `stopRecord`, `detune` and `overflow` are all zero, the mask is zero and the threshold is `THR_RESET` (0xFF).
- R2: A write with `wrSel`=1 loads `oscEnable` from `wrData[NUM_OSC-1:0]` on the next clock edge.
- R3: An alarm on an enabled, unmasked oscillator whose count has already reached the threshold shuts that oscillator down. Its `oscEnable` bit clears, its `stopRecord` bit sets and its count returns to zero, so with threshold T the (T+1)-th alarm shuts it down.
- R4: While an oscillator's mask bit is set (mask written with `wrSel`=3), its alarms neither count nor cause a shutdown.
- R5: Alarms on an oscillator whose enable bit is clear change nothing.
- R6: `overflow` sets when a shutdown occurs while `stopRecord` is already non-zero, or when two or more oscillators shut down in the same cycle. It then holds.
- R7: A write with `wrSel`=4 loads `stopRecord` from `wrData` and clears `overflow`. Otherwise stop bits only ever set.
- R8: `wrSel`=0 loads the threshold from `wrData[7:0]` and `wrSel`=2 loads `detune` from `wrData`. Writes with `wrSel` values 5 to 7 have no effect.
- R9: Writing a one to an oscillator's enable bit clears its alarm count, so a full T+1 further alarms are needed to shut it down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select (0 threshold, 1 enable, 2 detune, 3 mask, 4 stop) |
| wrData | input | 32 | Write data |
| alarmIn | input | NUM_OSC | Per-oscillator alarm pulses |
| oscEnable | output | NUM_OSC | Per-oscillator run enables |
| detune | output | 32 | Detune value passed to the oscillators |
| stopRecord | output | NUM_OSC | Sticky record of stopped oscillators |
| overflow | output | 1 | Sticky second-shutdown flag |

## Verification
The hardest situation to reach is a shutdown whose outcome depends on hidden counter state. Examples are an oscillator that carries a partial count across a re-enable, or one that was masked while alarms arrived. The counts cannot be seen at the ports, so each scenario drives an exact number of alarm pulses at a small threshold (3). It then checks that the enable stays up after the T-th pulse and drops only on the next one. The overflow path is reached in two ways: a second oscillator tripping while the first is still recorded, and two oscillators pulsed together until they trip in the same cycle.

// File: rtl/osc_alarm_pkg.sv
package osc_alarm_pkg;
  typedef enum logic [2:0] {
    SEL_THRESH = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_DETUNE = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_STOP   = 3'd4
  } regSel_e;

  typedef struct packed {
    logic thrWr;
    logic enWr;
    logic detWr;
    logic maskWr;
    logic stopWr;
  } regStrobe_t;
endpackage

// File: rtl/osc_alarm_ctrl.sv
module osc_alarm_ctrl
  import osc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       shutAny,
  input  logic       shutMulti,
  input  logic       stopAny,
  output regStrobe_t stb,
  output logic       overflow
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (wrSel)
        SEL_THRESH: stb.thrWr  = 1'b1;
        SEL_ENABLE: stb.enWr   = 1'b1;
        SEL_DETUNE: stb.detWr  = 1'b1;
        SEL_MASK:   stb.maskWr = 1'b1;
        SEL_STOP:   stb.stopWr = 1'b1;
        default:    stb = '0;
      endcase
    end
  end

  logic ovfSet;
  assign ovfSet = shutAny && (stopAny || shutMulti);

  always_ff @(posedge clk) begin
    if (!rstN)
      overflow <= 1'b0;
    else
      overflow <= (overflow && !stb.stopWr) || ovfSet;
  end

  // R6: the flag only ever rises right after a shutdown
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(shutAny));
  // R7: without a clear, the flag holds
  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !stb.stopWr) |=> overflow);
endmodule

// File: rtl/osc_alarm_dp.sv
module osc_alarm_dp
  import osc_alarm_pkg::*;
#(
  parameter int NUM_OSC   = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int DET_W     = 32,
  parameter logic [CNT_W-1:0] THR_RESET = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_OSC-1:0] alarmIn,
  output logic [NUM_OSC-1:0] oscEnable,
  output logic [DET_W-1:0]   detune,
  output logic [NUM_OSC-1:0] stopRecord,
  output logic               shutAny,
  output logic               shutMulti,
  output logic               stopAny
);
  logic [CNT_W-1:0]   threshold;
  logic [NUM_OSC-1:0] alarmMask;
  logic [NUM_OSC-1:0] trip;
  logic [NUM_OSC-1:0] wrOsc;
  logic [CNT_W-1:0]   alarmCnt [NUM_OSC];

  assign wrOsc = wrData[NUM_OSC-1:0];

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
    logic live;
    assign live    = alarmIn[i] && oscEnable[i] && !alarmMask[i];
    assign trip[i] = live && (alarmCnt[i] >= threshold);

    always_ff @(posedge clk) begin
      if (!rstN)
        alarmCnt[i] <= '0;
      else if ((stb.enWr && wrOsc[i]) || trip[i])
        alarmCnt[i] <= '0;
      else if (live)
        alarmCnt[i] <= alarmCnt[i] + 1'b1;
    end

    // R4, R5: a masked or stopped oscillator leaves its count alone
    assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rstN)
      ((alarmMask[i] || !oscEnable[i]) && !stb.enWr) |=> $stable(alarmCnt[i]));
    // R4: a masked or stopped oscillator never enters the stop record
    assert_mask_nostop_R4: assert property (@(posedge clk) disable iff (!rstN)
      ((alarmMask[i] || !oscEnable[i]) && !stb.stopWr) |=> (stopRecord[i] == $past(stopRecord[i])));
    // R3: an enable that drops without a write is always recorded
    assert_drop_recorded_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(oscEnable[i]) && !$past(stb.enWr)) |-> stopRecord[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threshold  <= THR_RESET;
      alarmMask  <= '0;
      oscEnable  <= '0;
      stopRecord <= '0;
      detune     <= '0;
    end else begin
      if (stb.thrWr)  threshold <= wrData[CNT_W-1:0];
      if (stb.maskWr) alarmMask <= wrOsc;
      if (stb.detWr)  detune    <= wrData[DET_W-1:0];
      oscEnable  <= stb.enWr ? wrOsc : (oscEnable & ~trip);
      stopRecord <= (stb.stopWr ? wrOsc : stopRecord) | trip;
    end
  end

  assign shutAny   = |trip;
  assign shutMulti = (trip & (trip - 1'b1)) != '0;
  assign stopAny   = |stopRecord;

  // R7: stop bits never clear without a stop write
  assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stopWr |=> ((stopRecord & $past(stopRecord)) == $past(stopRecord)));
endmodule

// File: rtl/osc_alarm_sup.sv
module osc_alarm_sup
  import osc_alarm_pkg::*;
#(
  parameter int NUM_OSC   = 32,
  parameter int CNT_W     = 8,
  parameter logic [CNT_W-1:0] THR_RESET = 8'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [31:0]        wrData,
  input  logic [NUM_OSC-1:0] alarmIn,
  output logic [NUM_OSC-1:0] oscEnable,
  output logic [31:0]        detune,
  output logic [NUM_OSC-1:0] stopRecord,
  output logic               overflow
);
  localparam int DATA_W = 32;
  localparam int DET_W  = DATA_W;

  regStrobe_t stb;
  logic shutAny, shutMulti, stopAny;

  osc_alarm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .shutAny(shutAny), .shutMulti(shutMulti), .stopAny(stopAny),
    .stb(stb), .overflow(overflow)
  );

  osc_alarm_dp #(
    .NUM_OSC(NUM_OSC), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .DET_W(DET_W), .THR_RESET(THR_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .alarmIn(alarmIn),
    .oscEnable(oscEnable), .detune(detune), .stopRecord(stopRecord),
    .shutAny(shutAny), .shutMulti(shutMulti), .stopAny(stopAny)
  );
endmodule

// File: tb/osc_alarm_sup_tb.sv
module osc_alarm_sup_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] alarmIn = '0;
  logic [31:0] oscEnable, detune, stopRecord;
  logic        overflow;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  osc_alarm_sup u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .alarmIn(alarmIn), .oscEnable(oscEnable), .detune(detune),
    .stopRecord(stopRecord), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [31:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); alarmIn = v;
      @(negedge clk); alarmIn = '0;
    end
  endtask

  task automatic tReset;
    chk("R1 enable", oscEnable, 32'h0);
    chk("R1 stop", stopRecord, 32'h0);
    chk("R1 detune", detune, 32'h0);
    chk("R1 overflow", {31'b0, overflow}, 32'h0);
  endtask

  task automatic tDefaultThreshold;
    // R1: default threshold 0xFF, so 255 alarms keep osc 2 running
    regWrite(3'd1, 32'h0000_0004);
    pulse(32'h4, 255);
    chk("R1 thr 0xFF holds", oscEnable, 32'h4);
    pulse(32'h4, 1);
    chk("R1 thr 0xFF trips", stopRecord, 32'h4);
    regWrite(3'd4, 32'h0);
  endtask

  task automatic tWrites;
    regWrite(3'd1, 32'hFFFF_FFFF);
    chk("R2 enable all", oscEnable, 32'hFFFF_FFFF);
    regWrite(3'd2, 32'h0000_05A5);
    chk("R8 detune", detune, 32'h0000_05A5);
    regWrite(3'd7, 32'h0);
    regWrite(3'd5, 32'h0);
    chk("R8 bad sel enable", oscEnable, 32'hFFFF_FFFF);
    chk("R8 bad sel detune", detune, 32'h0000_05A5);
    regWrite(3'd0, 32'd3);
  endtask

  task automatic tShutdown;
    pulse(32'h1, 3);
    chk("R3 below thr", oscEnable, 32'hFFFF_FFFF);
    pulse(32'h1, 1);
    chk("R3 enable drop", oscEnable, 32'hFFFF_FFFE);
    chk("R3 stop set", stopRecord, 32'h1);
    chk("R6 no ovf first", {31'b0, overflow}, 32'h0);
    pulse(32'h1, 6);
    chk("R5 disabled ignored stop", stopRecord, 32'h1);
    chk("R5 disabled ignored ovf", {31'b0, overflow}, 32'h0);
  endtask

  task automatic tReenable;
    pulse(32'h2, 2);
    regWrite(3'd1, 32'hFFFF_FFFF);
    pulse(32'h2, 3);
    chk("R9 count cleared", oscEnable, 32'hFFFF_FFFF);
    pulse(32'h2, 1);
    chk("R9 trip after full", oscEnable, 32'hFFFF_FFFD);
    chk("R6 second ovf", {31'b0, overflow}, 32'h1);
    chk("R6 stop both", stopRecord, 32'h3);
  endtask

  task automatic tStopClear;
    regWrite(3'd4, 32'h0);
    chk("R7 stop clear", stopRecord, 32'h0);
    chk("R7 ovf clear", {31'b0, overflow}, 32'h0);
    regWrite(3'd1, 32'hFFFF_FFFF);
    pulse(32'h30, 4);
    chk("R6 multi enable", oscEnable, 32'hFFFF_FFCF);
    chk("R6 multi ovf", {31'b0, overflow}, 32'h1);
    regWrite(3'd4, 32'h0);
  endtask

  task automatic tMask;
    regWrite(3'd1, 32'hFFFF_FFFF);
    regWrite(3'd3, 32'h100);
    pulse(32'h100, 10);
    chk("R4 masked enable", oscEnable, 32'hFFFF_FFFF);
    chk("R4 masked stop", stopRecord, 32'h0);
    regWrite(3'd3, 32'h0);
    pulse(32'h100, 3);
    chk("R4 no count kept", oscEnable, 32'hFFFF_FFFF);
    pulse(32'h100, 1);
    chk("R4 unmasked trips", stopRecord, 32'h100);
    chk("R6 single no ovf", {31'b0, overflow}, 32'h0);
  endtask

  task automatic tThreshZero;
    regWrite(3'd4, 32'h0);
    regWrite(3'd1, 32'hFFFF_FFFF);
    regWrite(3'd0, 32'd0);
    pulse(32'h8000_0000, 1);
    chk("R8 thr0 enable", oscEnable, 32'h7FFF_FFFF);
    chk("R8 thr0 stop", stopRecord, 32'h8000_0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDefaultThreshold();
    tWrites();
    tShutdown();
    tReenable();
    tStopClear();
    tMask();
    tThreshZero();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule